// File: doc/BRIEF.md
# PMP configuration register file

This block stores the state that programs a physical memory protection unit: one configuration byte and one address register for each protection entry, plus a small machine security register. Software reaches all of it through a single-cycle register port. The port carries a write enable, a register-class select, a register index and write data. Read data is combinational. Every entry's configuration byte and address, and the security bits, are also driven in parallel to the downstream range-decode and permission-check logic.

Each configuration byte lays out its fields as follows: read in bit 0, write in bit 1, execute in bit 2, match mode in bits 4:3 (01 is top-of-range) and lock in bit 7. A configuration register holds one byte per entry, and the lowest byte belongs to the lowest entry. The block decides, one byte at a time, whether a write takes effect. The decision depends on the entry's lock bit and on the security bits.

The security register has three bits. Bit 0 is lockdown, which tightens the acceptance rules. Bit 1 is deny-by-default, which is only held and exported. Bit 2 is the lock bypass. When the `ENHANCED` parameter is 0, the security register does not exist and only the plain lock rule applies. The block has no state machine. Its only sequential elements are the registers, each of which loads at the clock edge after an accepted write.

Top module: `pmp_csr_file`

## Requirements
- R1: After reset, every configuration byte, every address register and the security register read as zero, both on the port and on the parallel outputs.
- R2: A configuration write to index k offers byte lane j (bits 8j+7:8j) to entry 4k+j. An accepted byte appears on the parallel outputs one clock later. A configuration read returns the entries' bytes packed in the same order.
- R3: While bypass and lockdown are both clear, and always when `ENHANCED` is 0, a byte aimed at an entry whose lock bit (bit 7) is set is dropped. Other lanes of the same write still land.
- R4: When `ENHANCED` is 1 and bypass (security bit 2) is set, every configuration byte is accepted, including bytes for locked entries.
- R5: When `ENHANCED` is 1, lockdown (security bit 0) is set and bypass is clear, a configuration byte is accepted only in two cases. Either the new byte has lock set and execute clear, or it has lock clear and its bits 2:0 differ from 3'b110. The current lock bit of the entry does not matter.
- R6: An address register write is dropped in two cases: its own entry is locked, or the next higher entry is locked with match mode 01. In all other cases it is stored.
- R7: Once set, lockdown (bit 0) and deny-by-default (bit 1) of the security register stay set, whatever is written.
- R8: A security write cannot raise bypass from 0 to 1 while any entry's lock bit is set. The same write may still clear bypass.
- R9: Writes to configuration bytes or address registers beyond the implemented entry count are ignored, and reads of them return zero. Select value 3 reads zero and writes nothing.
- R10: With `ENHANCED` = 0, the security register reads zero and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe, one write per cycle |
| csr_sel | input | 2 | Register class: 0 configuration, 1 address, 2 security, 3 none |
| csr_idx | input | IDX_W | Register index within the class |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for the selected register |
| ent_cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, entry i at bits 8i+7:8i |
| ent_addr_o | output | NUM_ENTRIES*XLEN | All address registers, entry i at slice i |
| sec_cfg_o | output | 3 | Security bits: 0 lockdown, 1 deny-by-default, 2 bypass |

## Verification
Read data depends only on the current register state and the port inputs. The bench therefore checks it 2 ns after driving the inputs on a falling edge, within the same cycle. An accepted write changes the parallel outputs and the security bits at the next rising edge. The bench compares the whole visible state at the falling edge that follows, against a behavioural model that it updates when it issues the write. Two instances, one enhanced and one plain, receive identical stimulus, so each lock and lockdown case is checked under both rule sets.

// File: rtl/pmp_csr_pkg.sv
package pmp_csr_pkg;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_SEC  = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    localparam int BIT_R   = 0;
    localparam int BIT_W   = 1;
    localparam int BIT_X   = 2;
    localparam int MODE_LO = 3;
    localparam int BIT_L   = 7;

    localparam logic [1:0] MODE_TOR = 2'b01;

    localparam int SEC_LOCKDOWN = 0;
    localparam int SEC_DENYDEF  = 1;
    localparam int SEC_BYPASS   = 2;
    localparam int SEC_W        = 3;

    function automatic logic tor_locked(input logic [7:0] c);
        return c[BIT_L] && (c[MODE_LO+1:MODE_LO] == MODE_TOR);
    endfunction

endpackage

// File: rtl/pmp_write_gate.sv
module pmp_write_gate
    import pmp_csr_pkg::*;
#(
    parameter bit ENHANCED = 1'b1
) (
    input  logic [7:0]       cur_cfg_i,
    input  logic [7:0]       new_cfg_i,
    input  logic [7:0]       next_cfg_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic             cfg_ok_o,
    output logic             addr_ok_o
);

    logic unused_bits;
    assign unused_bits = ^{new_cfg_i[6:3], sec_i[SEC_DENYDEF]};

    generate
        if (ENHANCED) begin : g_enh
            logic shape_ok;
            always_comb begin
                shape_ok = (new_cfg_i[BIT_L] && !new_cfg_i[BIT_X]) ||
                           (!new_cfg_i[BIT_L] && (new_cfg_i[BIT_X:BIT_R] != 3'b110));
                cfg_ok_o = sec_i[SEC_BYPASS] ||
                           (!sec_i[SEC_LOCKDOWN] && !cur_cfg_i[BIT_L]) ||
                           (sec_i[SEC_LOCKDOWN] && shape_ok);
            end
        end else begin : g_plain
            logic unused_plain;
            assign unused_plain = ^{new_cfg_i, sec_i};
            assign cfg_ok_o = !cur_cfg_i[BIT_L];
        end
    endgenerate

    assign addr_ok_o = !cur_cfg_i[BIT_L] && !tor_locked(next_cfg_i);

endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
    import pmp_csr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit ENHANCED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [7:0]       cfg_wdata_i,
    input  logic             addr_we_i,
    input  logic [XLEN-1:0]  addr_wdata_i,
    input  logic [7:0]       next_cfg_i,
    input  logic [SEC_W-1:0] sec_i,
    output logic [7:0]       cfg_o,
    output logic [XLEN-1:0]  addr_o
);

    logic [7:0]      cfg_q;
    logic [XLEN-1:0] addr_q;
    logic            cfg_ok;
    logic            addr_ok;

    pmp_write_gate #(.ENHANCED(ENHANCED)) u_gate (
        .cur_cfg_i (cfg_q),
        .new_cfg_i (cfg_wdata_i),
        .next_cfg_i(next_cfg_i),
        .sec_i     (sec_i),
        .cfg_ok_o  (cfg_ok),
        .addr_ok_o (addr_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else begin
            if (cfg_we_i && cfg_ok)    cfg_q  <= cfg_wdata_i;
            if (addr_we_i && addr_ok)  addr_q <= addr_wdata_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;

    // R3: a locked byte cannot change unless bypass or lockdown is active
    a_r3_locked_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[BIT_L] && !sec_i[SEC_BYPASS] && !sec_i[SEC_LOCKDOWN]) |=> $stable(cfg_q));

    // R6: own lock freezes the address register
    a_r6_addr_own_lock: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[BIT_L] |=> $stable(addr_q));

    // R6: a locked top-of-range neighbour freezes the address register
    a_r6_addr_next_tor: assert property (@(posedge clk) disable iff (!rst_n)
        (next_cfg_i[BIT_L] && next_cfg_i[MODE_LO+1:MODE_LO] == MODE_TOR) |=> $stable(addr_q));

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
    import pmp_csr_pkg::*;
#(
    parameter bit ENHANCED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SEC_W-1:0] wdata_i,
    input  logic             any_locked_i,
    output logic [SEC_W-1:0] sec_o
);

    generate
        if (ENHANCED) begin : g_enh
            logic [SEC_W-1:0] sec_q;
            logic [SEC_W-1:0] sec_d;

            always_comb begin
                sec_d = wdata_i;
                if (!sec_q[SEC_BYPASS] && any_locked_i) sec_d[SEC_BYPASS] = 1'b0;
                sec_d[SEC_LOCKDOWN] = sec_d[SEC_LOCKDOWN] | sec_q[SEC_LOCKDOWN];
                sec_d[SEC_DENYDEF]  = sec_d[SEC_DENYDEF]  | sec_q[SEC_DENYDEF];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    sec_q <= '0;
                else if (we_i) sec_q <= sec_d;
            end

            assign sec_o = sec_q;

            // R7: sticky lockdown
            a_r7_lockdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                sec_q[SEC_LOCKDOWN] |=> sec_q[SEC_LOCKDOWN]);
            // R7: sticky deny-by-default
            a_r7_denydef_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                sec_q[SEC_DENYDEF] |=> sec_q[SEC_DENYDEF]);
            // R8: bypass cannot rise while an entry is locked
            a_r8_bypass_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
                (!sec_q[SEC_BYPASS] && any_locked_i) |=> !sec_q[SEC_BYPASS]);
        end else begin : g_plain
            logic unused_in;
            assign unused_in = ^{clk, rst_n, we_i, wdata_i, any_locked_i};
            assign sec_o = '0;
        end
    endgenerate

endmodule

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
    import pmp_csr_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int XLEN        = 32,
    parameter int IDX_W       = 6,
    parameter bit ENHANCED    = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_we,
    input  logic [1:0]                  csr_sel,
    input  logic [IDX_W-1:0]            csr_idx,
    input  logic [XLEN-1:0]             csr_wdata,
    output logic [XLEN-1:0]             csr_rdata,
    output logic [NUM_ENTRIES*8-1:0]    ent_cfg_o,
    output logic [NUM_ENTRIES*XLEN-1:0] ent_addr_o,
    output logic [SEC_W-1:0]            sec_cfg_o
);

    localparam int LANES        = XLEN / 8;
    localparam int ENTRY_STRIDE = 4;

    csr_sel_e        sel;
    logic [7:0]      cfg_arr   [NUM_ENTRIES];
    logic [XLEN-1:0] addr_arr  [NUM_ENTRIES];
    logic [7:0]      cfg_byte  [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] cfg_we;
    logic [NUM_ENTRIES-1:0] addr_we;
    logic [NUM_ENTRIES-1:0] lock_vec;
    logic [SEC_W-1:0] sec;
    logic             cfg_wr;
    logic             odd_reject;

    assign sel        = csr_sel_e'(csr_sel);
    assign odd_reject = (LANES == 8) && csr_idx[0];
    assign cfg_wr     = csr_we && (sel == SEL_CFG) && !odd_reject;

    always_comb begin
        int base;
        base = int'(csr_idx) * ENTRY_STRIDE;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            cfg_we[i]   = 1'b0;
            cfg_byte[i] = '0;
            addr_we[i]  = csr_we && (sel == SEL_ADDR) && (int'(csr_idx) == i);
            if (i >= base && i < base + LANES) begin
                cfg_we[i]   = cfg_wr;
                cfg_byte[i] = csr_wdata[(i - base) * 8 +: 8];
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            logic [7:0] next_cfg;
            if (g < NUM_ENTRIES - 1) begin : g_has_next
                assign next_cfg = cfg_arr[g+1];
            end else begin : g_top
                assign next_cfg = '0;
            end

            pmp_entry #(.XLEN(XLEN), .ENHANCED(ENHANCED)) u_entry (
                .clk         (clk),
                .rst_n       (rst_n),
                .cfg_we_i    (cfg_we[g]),
                .cfg_wdata_i (cfg_byte[g]),
                .addr_we_i   (addr_we[g]),
                .addr_wdata_i(csr_wdata),
                .next_cfg_i  (next_cfg),
                .sec_i       (sec),
                .cfg_o       (cfg_arr[g]),
                .addr_o      (addr_arr[g])
            );

            assign lock_vec[g]                 = cfg_arr[g][BIT_L];
            assign ent_cfg_o[g*8 +: 8]         = cfg_arr[g];
            assign ent_addr_o[g*XLEN +: XLEN]  = addr_arr[g];
        end
    endgenerate

    pmp_sec_reg #(.ENHANCED(ENHANCED)) u_sec (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (csr_we && (sel == SEL_SEC)),
        .wdata_i     (csr_wdata[SEC_W-1:0]),
        .any_locked_i(|lock_vec),
        .sec_o       (sec)
    );

    assign sec_cfg_o = sec;

    always_comb begin
        int base;
        base      = int'(csr_idx) * ENTRY_STRIDE;
        csr_rdata = '0;
        unique case (sel)
            SEL_CFG: begin
                for (int l = 0; l < LANES; l++) begin
                    if (base + l < NUM_ENTRIES) csr_rdata[l*8 +: 8] = cfg_arr[base + l];
                end
            end
            SEL_ADDR: begin
                if (int'(csr_idx) < NUM_ENTRIES) csr_rdata = addr_arr[int'(csr_idx)];
            end
            SEL_SEC:  csr_rdata[SEC_W-1:0] = sec;
            SEL_NONE: csr_rdata = '0;
        endcase
    end

    // R9: select value 3 never returns data
    a_r9_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (csr_rdata == '0));

endmodule

// File: tb/pmp_csr_file_tb.sv
module pmp_csr_file_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_sel = 2'd0;
    logic [5:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;

    logic [31:0]     rd_e, rd_p;
    logic [N*8-1:0]  cfg_e, cfg_p;
    logic [N*32-1:0] addr_e, addr_p;
    logic [2:0]      sec_e, sec_p;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    pmp_csr_file #(.ENHANCED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .csr_rdata(rd_e), .ent_cfg_o(cfg_e), .ent_addr_o(addr_e),
        .sec_cfg_o(sec_e));

    pmp_csr_file #(.ENHANCED(1'b0)) u_dut_plain (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .csr_rdata(rd_p), .ent_cfg_o(cfg_p), .ent_addr_o(addr_p),
        .sec_cfg_o(sec_p));

    // behavioural model, index 0 = enhanced, 1 = plain
    logic [7:0]  m_cfg  [2][N];
    logic [31:0] m_addr [2][N];
    logic [2:0]  m_sec  [2];

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            m_sec[m] = '0;
            for (int i = 0; i < N; i++) begin
                m_cfg[m][i]  = '0;
                m_addr[m][i] = '0;
            end
        end
    endtask

    function automatic logic [31:0] mread(int m, logic [1:0] s, int idx);
        logic [31:0] v = '0;
        case (s)
            2'd0: for (int l = 0; l < 4; l++) if (idx*4 + l < N) v[l*8 +: 8] = m_cfg[m][idx*4 + l];
            2'd1: if (idx < N) v = m_addr[m][idx];
            2'd2: v[2:0] = m_sec[m];
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic mwrite(int m, logic [1:0] s, int idx, logic [31:0] d);
        bit enh = (m == 0);
        logic [2:0] v;
        bit any_l = 0;
        if (s == 2'd0) begin
            for (int l = 0; l < 4; l++) begin
                int e = idx*4 + l;
                if (e < N) begin
                    logic [7:0] nb = d[l*8 +: 8];
                    bit ok;
                    if (enh) begin
                        ok = 0;
                        if (m_sec[m][2]) ok = 1;
                        if (!m_sec[m][0] && !m_cfg[m][e][7]) ok = 1;
                        if (m_sec[m][0] && nb[7] && !nb[2]) ok = 1;
                        if (m_sec[m][0] && !nb[7] && nb[2:0] != 3'b110) ok = 1;
                    end else begin
                        ok = !m_cfg[m][e][7];
                    end
                    if (ok) m_cfg[m][e] = nb;
                end
            end
        end else if (s == 2'd1) begin
            if (idx < N) begin
                bit blocked = m_cfg[m][idx][7];
                if (idx + 1 < N && m_cfg[m][idx+1][7] && m_cfg[m][idx+1][4:3] == 2'b01) blocked = 1;
                if (!blocked) m_addr[m][idx] = d;
            end
        end else if (s == 2'd2 && enh) begin
            for (int i = 0; i < N; i++) if (m_cfg[m][i][7]) any_l = 1;
            v = d[2:0];
            if (!m_sec[m][2] && any_l) v[2] = 1'b0;
            v = v | (m_sec[m] & 3'b011);
            m_sec[m] = v;
        end
    endtask

    task automatic chk(string req, string what, logic [N*32-1:0] act, logic [N*32-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_state(string req);
        logic [N*8-1:0]  ec;
        logic [N*32-1:0] ea;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < N; i++) begin
                ec[i*8 +: 8]   = m_cfg[m][i];
                ea[i*32 +: 32] = m_addr[m][i];
            end
            if (m == 0) begin
                chk(req, "enh cfg",  {{(N*24){1'b0}}, cfg_e}, {{(N*24){1'b0}}, ec});
                chk(req, "enh addr", addr_e, ea);
                chk(req, "enh sec",  {{(N*32-3){1'b0}}, sec_e}, {{(N*32-3){1'b0}}, m_sec[0]});
            end else begin
                chk(req, "plain cfg",  {{(N*24){1'b0}}, cfg_p}, {{(N*24){1'b0}}, ec});
                chk(req, "plain addr", addr_p, ea);
                chk(req, "plain sec",  {{(N*32-3){1'b0}}, sec_p}, {{(N*32-3){1'b0}}, m_sec[1]});
            end
        end
    endtask

    // one port operation: read checked in-cycle, state checked after the edge
    task automatic op(bit we, logic [1:0] s, int idx, logic [31:0] d, string req);
        @(negedge clk);
        csr_we = we; csr_sel = s; csr_idx = idx[5:0]; csr_wdata = d;
        #2;
        chk(req, "enh rdata",   {{(N*32-32){1'b0}}, rd_e}, {{(N*32-32){1'b0}}, mread(0, s, idx)});
        chk(req, "plain rdata", {{(N*32-32){1'b0}}, rd_p}, {{(N*32-32){1'b0}}, mread(1, s, idx)});
        if (we) begin
            mwrite(0, s, idx, d);
            mwrite(1, s, idx, d);
        end
        @(negedge clk);
        csr_we = 1'b0;
        compare_state(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; csr_we = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        compare_state("R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        op(0, 2'd0, 0, '0, "R1");
        op(0, 2'd1, 7, '0, "R1");
        op(0, 2'd2, 0, '0, "R1");

        // R2 packing and read-back
        op(1, 2'd0, 0, 32'h1F0F_0B03, "R2");
        op(0, 2'd0, 0, '0, "R2");
        op(1, 2'd0, 3, 32'h0907_0503, "R2");
        op(0, 2'd0, 3, '0, "R2");
        for (int i = 0; i < N; i++) op(1, 2'd1, i, 32'h1000_0000 + i*16, "R2");
        op(0, 2'd1, 5, '0, "R2");

        // R3 lock entry 1 as top-of-range, then try to overwrite all lanes
        op(1, 2'd0, 0, 32'h0000_8A00, "R3");
        op(1, 2'd0, 0, 32'h1111_1111, "R3");
        op(0, 2'd0, 0, '0, "R3");

        // R6 address write blocking
        op(1, 2'd1, 1, 32'hDEAD_0001, "R6");
        op(1, 2'd1, 0, 32'hDEAD_0000, "R6");
        op(1, 2'd1, 2, 32'hBEEF_0002, "R6");
        op(1, 2'd0, 1, 32'h0000_9000, "R6");
        op(1, 2'd1, 4, 32'hBEEF_0004, "R6");
        op(1, 2'd1, 5, 32'hBEEF_0005, "R6");

        // R9 out of range
        op(1, 2'd0, 4, 32'hFFFF_FFFF, "R9");
        op(0, 2'd0, 4, '0, "R9");
        op(1, 2'd1, 16, 32'hFFFF_FFFF, "R9");
        op(0, 2'd1, 40, '0, "R9");
        op(1, 2'd3, 0, 32'hFFFF_FFFF, "R9");
        op(0, 2'd3, 0, '0, "R9");

        // R8 bypass cannot rise with locks present; R10 plain ignores
        op(1, 2'd2, 0, 32'h0000_0004, "R8");
        op(0, 2'd2, 0, '0, "R10");
        op(1, 2'd2, 0, 32'h0000_0002, "R7");
        op(1, 2'd2, 0, 32'h0000_0000, "R7");
        op(0, 2'd2, 0, '0, "R10");

        // R4 bypass
        do_reset();
        op(1, 2'd2, 0, 32'h0000_0004, "R4");
        op(1, 2'd0, 0, 32'h8080_8080, "R4");
        op(1, 2'd0, 0, 32'h0000_8001, "R4");
        op(0, 2'd0, 0, '0, "R4");
        op(1, 2'd2, 0, 32'h0000_0000, "R8");
        op(1, 2'd2, 0, 32'h0000_0004, "R8");

        // R7 lockdown sticky, then R5 lockdown acceptance rules
        op(1, 2'd2, 0, 32'h0000_0001, "R7");
        op(1, 2'd2, 0, 32'h0000_0000, "R7");
        op(1, 2'd0, 1, 32'h0603_8584, "R5");
        op(0, 2'd0, 1, '0, "R5");
        op(1, 2'd0, 1, 32'h0000_0083, "R5");
        op(1, 2'd0, 0, 32'h0000_8300, "R5");
        op(1, 2'd0, 0, 32'h0000_8400, "R5");
        op(0, 2'd0, 0, '0, "R5");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule